// File: doc/BRIEF.md
# Serial EEPROM Page Write Engine

This block sits behind the two-wire protocol controller of a serial EEPROM model. The controller hands it a start address taken from a dummy-write sequence, one strobe for each received data byte, a strobe for each byte delivered by a read, and a strobe when a stop condition ends a transfer. Data bytes are collected in a 32-byte page buffer. The address within the page advances after each byte and wraps inside the page, so a later byte overwrites an earlier one at the same position. A per-byte valid mask records which positions were actually received.

A stop condition that follows at least one data byte starts a timed internal write cycle. During that cycle `busy` is high, the buffered bytes are written one at a time to a behavioural memory array, and every strobe from the controller is ignored. The controller answers completion polling with a nack while `busy` is high. A level write-protect input blocks the top part of the array, and each byte is checked against it as the byte enters the buffer. The block also keeps the current address counter that reads use.

Top module: `eeprom_page_writer`

## Requirements
- R1: On commit, every buffer position that received an unblocked byte is written once to the array at {page, position}. Positions that received no byte are not written.
- R2: The in-page position is address bits [4:0]. After position 31 it wraps to position 0 of the same page, and a byte received later at a position replaces the earlier byte there.
- R3: A stop strobe starts a write cycle only if at least one data byte has been received since the last address load or the last completed cycle. Otherwise `busy` stays low and nothing is written.
- R4: `busy` rises in the cycle after the accepted stop strobe and stays high for exactly WC_CYCLES cycles. `mem_we` is asserted only while `busy` is high.
- R5: While `busy` is high, the address load, data byte, stop and read strobes have no effect: `cur_addr` does not change and no extra array write follows.
- R6: With `wp_level` high, a byte whose address has its top bits all one is dropped and never written. This is the top quarter of the array when ADDR_W is 12 or more, and the top half when ADDR_W is 11 or less. With `wp_level` low, every address is written.
- R7: After each accepted data byte, `cur_addr` holds the same page with position (previous position + 1) mod 32.
- R8: Each accepted read strobe advances `cur_addr` by one modulo 2^ADDR_W, so the address after the last one is 0.
- R9: An accepted address load sets `cur_addr` to `load_addr` in the next cycle.
- R10: During and right after reset, `busy` and `mem_we` are low.
- R11: Protection is decided per byte from the value of `wp_level` in the cycle that byte is accepted, so changing `wp_level` within one page affects only the bytes accepted after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load `load_addr` as the current address (dummy write) |
| load_addr | input | ADDR_W | Address to load |
| byte_valid | input | 1 | One received write-data byte |
| byte_data | input | 8 | Write-data byte |
| stop_seen | input | 1 | Stop condition observed |
| rd_step | input | 1 | One read byte delivered |
| wp_level | input | 1 | Write-protect level |
| busy | output | 1 | Internal write cycle in progress |
| cur_addr | output | ADDR_W | Current address counter |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that the controller raises at most one of the four strobes in any cycle, and one of them checks this assumption. They also assume that WC_CYCLES is at least the page size, so the scan of the buffer ends before `busy` falls. The bench drives each strobe for exactly one cycle from a task and waits for `busy` to fall before it starts the next transfer. The strobes that arrive while `busy` is high are sent on purpose, one at a time, to show that they are ignored. `wp_level` changes only between bytes.

// File: rtl/eeprom_pw_pkg.sv
// Package: constants shared by the page write engine.
// Assumes a fixed 32-byte page; the array depth is a module parameter.
package eeprom_pw_pkg;
    localparam int PAGE_AW    = 5;
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    // Number of top address bits that select the protected region.
    function automatic int prot_bits(input int addr_w);
        return (addr_w <= 11) ? 1 : 2;
    endfunction
endpackage

// File: rtl/epw_addr_ctr.sv
// Current address counter.
// Data bytes advance only the in-page bits and wrap inside the page.
// Read bytes advance the whole address and wrap at the top of the array.
// Assumes the caller has already gated all steps with the busy flag.
module epw_addr_ctr
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              page_step,
    input  logic              lin_step,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_AW-1:0] next_pos;

    // Next position inside the page, wrapping from the last byte to the first.
    always_comb begin
        next_pos = addr[PAGE_AW-1:0] + 1'b1;
    end

    // Update the counter on a load, a data byte or a read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (page_step) begin
            addr <= {addr[ADDR_W-1:PAGE_AW], next_pos};
        end else if (lin_step) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/epw_wp_guard.sv
// Write-protect decode.
// A byte is blocked when the protect level is high and its address lies in
// the top region of the array. The region is half of the array for the small
// densities and a quarter for the large ones.
module epw_wp_guard
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              wp_level,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);
    localparam int PB = prot_bits(ADDR_W);

    // The top PB address bits all one select the protected region.
    always_comb begin
        blocked = wp_level & (&addr[ADDR_W-1 -: PB]);
    end
endmodule

// File: rtl/epw_page_buf.sv
// Page buffer: 32 data slots, a valid bit per slot and a flag that any byte
// arrived. A write sets the slot's valid bit to `keep`, so a blocked byte
// clears it. The clear input empties the mask and the flag.
// Assumes `clr` and `we` never arrive in the same cycle.
module epw_page_buf
    import eeprom_pw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [7:0]         wr_data,
    input  logic               keep,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    output logic               has_data
);
    logic [7:0]            slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        // Store one slot and its valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s]  <= 1'b0;
                slot_data[s] <= '0;
            end else if (clr) begin
                slot_vld[s]  <= 1'b0;
            end else if (we && (wr_idx == PAGE_AW'(s))) begin
                slot_vld[s]  <= keep;
                slot_data[s] <= wr_data;
            end
        end
    end

    // Remember whether any byte arrived since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_data <= 1'b0;
        end else if (clr) begin
            has_data <= 1'b0;
        end else if (we) begin
            has_data <= 1'b1;
        end
    end

    // Read port used by the commit scan.
    always_comb begin
        rd_data  = slot_data[rd_idx];
        rd_valid = slot_vld[rd_idx];
    end
endmodule

// File: rtl/epw_commit_timer.sv
// Write cycle timer. A start pulse raises busy for exactly WC_CYCLES clocks.
// During the first PAGE_BYTES of those clocks it presents a scan index so the
// buffer can be written out. Assumes WC_CYCLES >= PAGE_BYTES.
module epw_commit_timer
    import eeprom_pw_pkg::*;
#(
    parameter int WC_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               scan_act,
    output logic [PAGE_AW-1:0] scan_idx,
    output logic               done
);
    localparam int CNT_W = $clog2(WC_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // End of the cycle and the scan window, both taken from the count.
    always_comb begin
        done     = busy && (cnt == CNT_W'(WC_CYCLES - 1));
        scan_act = busy && (cnt < CNT_W'(PAGE_BYTES));
        scan_idx = cnt[PAGE_AW-1:0];
    end

    // Run the counter from start until the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= start;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
// Top of the page write engine. The controller strobes are gated by busy, so
// nothing but the timer moves during a write cycle. Bytes enter the page
// buffer with their protect decision. A stop strobe that follows data starts
// the timer, which writes out the valid slots at {page, slot}.
// Assumes at most one strobe per cycle.
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int WC_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              stop_seen,
    input  logic              rd_step,
    input  logic              wp_level,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    logic               ld_ok, byte_ok, stop_ok, rd_ok;
    logic               blocked, has_data, commit_done, start;
    logic               scan_act, slot_valid;
    logic [PAGE_AW-1:0] scan_idx;
    logic [7:0]         slot_data;

    // Gate every controller strobe with busy.
    always_comb begin
        ld_ok   = addr_load  & ~busy;
        byte_ok = byte_valid & ~busy;
        stop_ok = stop_seen  & ~busy;
        rd_ok   = rd_step    & ~busy;
        start   = stop_ok & has_data;
    end

    epw_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_ok),
        .load_addr (load_addr),
        .page_step (byte_ok),
        .lin_step  (rd_ok),
        .addr      (cur_addr)
    );

    epw_wp_guard #(.ADDR_W(ADDR_W)) u_guard (
        .wp_level (wp_level),
        .addr     (cur_addr),
        .blocked  (blocked)
    );

    epw_page_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ld_ok | commit_done),
        .we       (byte_ok),
        .wr_idx   (cur_addr[PAGE_AW-1:0]),
        .wr_data  (byte_data),
        .keep     (~blocked),
        .rd_idx   (scan_idx),
        .rd_data  (slot_data),
        .rd_valid (slot_valid),
        .has_data (has_data)
    );

    epw_commit_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .scan_act (scan_act),
        .scan_idx (scan_idx),
        .done     (commit_done)
    );

    // Array write port driven by the scan; the page comes from the held address.
    always_comb begin
        mem_we    = scan_act & slot_valid;
        mem_addr  = {cur_addr[ADDR_W-1:PAGE_AW], scan_idx};
        mem_wdata = slot_data;
    end

    // Input assumption: the controller raises at most one strobe per cycle.
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load, byte_valid, stop_seen, rd_step}));

    p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_busy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen && has_data));

    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr));

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && !busy) |=> (cur_addr == $past(load_addr)));

    p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !busy) |=> (cur_addr == $past(cur_addr) + 1'b1));

    p_page_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !busy && (&cur_addr[PAGE_AW-1:0]))
        |=> ((cur_addr[PAGE_AW-1:0] == '0)
             && (cur_addr[ADDR_W-1:PAGE_AW] == $past(cur_addr[ADDR_W-1:PAGE_AW]))));

    p_no_we_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_we));
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb_top;
    localparam int AW = 13;
    localparam int WC = 48;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0, byte_valid = 1'b0, stop_seen = 1'b0, rd_step = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0]    byte_data = '0;
    logic          wp_level = 1'b0;
    logic          busy, mem_we;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [7:0]    mem_wdata;

    int   n_chk = 0, n_err = 0, n_wr = 0;
    logic [7:0] wval [DEPTH];
    bit         wflg [DEPTH];

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_seen(stop_seen),
        .rd_step(rd_step), .wp_level(wp_level), .busy(busy), .cur_addr(cur_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Log array writes away from the active edge.
    always @(negedge clk) begin
        if (mem_we) begin
            n_wr++;
            wflg[mem_addr] = 1'b1;
            wval[mem_addr] = mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < DEPTH; i++) wflg[i] = 1'b0;
        n_wr = 0;
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        @(negedge clk); addr_load = 1'b1; load_addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_step = 1'b1;
        @(negedge clk); rd_step = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0 && mem_we == 1'b0, "R10 reset", {busy, mem_we}, 0);
    endtask

    task automatic t_single();
        int len;
        clear_log();
        do_load(13'h0123);
        chk(cur_addr == 13'h0123, "R9 load", cur_addr, 13'h0123);
        do_byte(8'h5A);
        chk(cur_addr == 13'h0124, "R7 advance", cur_addr, 13'h0124);
        do_stop();
        len = 0;
        while (busy) begin len++; @(negedge clk); end
        chk(len == WC, "R4 busy length", len, WC);
        chk(n_wr == 1, "R1 write count", n_wr, 1);
        chk(wflg[13'h0123] && wval[13'h0123] == 8'h5A, "R1 data", wval[13'h0123], 8'h5A);
    endtask

    task automatic t_wrap();
        clear_log();
        do_load(13'h005E);
        do_byte(8'hA0); do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
        chk(cur_addr == 13'h0042, "R2 wrap address", cur_addr, 13'h0042);
        do_stop(); wait_idle();
        chk(n_wr == 4, "R2 wrap count", n_wr, 4);
        chk(wval[13'h005E] == 8'hA0 && wval[13'h005F] == 8'hA1, "R2 page tail",
            {wval[13'h005E], wval[13'h005F]}, 16'hA0A1);
        chk(wval[13'h0040] == 8'hA2 && wval[13'h0041] == 8'hA3 && !wflg[13'h0060],
            "R2 page head", {wval[13'h0040], wval[13'h0041]}, 16'hA2A3);
        clear_log();
        do_load(13'h0060);
        for (int i = 0; i < 34; i++) do_byte(8'(8'h10 + i));
        do_stop(); wait_idle();
        chk(n_wr == 32, "R1 full page count", n_wr, 32);
        chk(wval[13'h0060] == 8'h30 && wval[13'h0061] == 8'h31, "R2 overwrite",
            {wval[13'h0060], wval[13'h0061]}, 16'h3031);
        chk(wval[13'h0062] == 8'h12 && wval[13'h007F] == 8'h2F, "R1 page body",
            {wval[13'h0062], wval[13'h007F]}, 16'h122F);
    endtask

    task automatic t_no_data();
        clear_log();
        do_load(13'h0200);
        do_stop();
        for (int i = 0; i < 4; i++) begin
            chk(busy == 1'b0, "R3 no cycle", busy, 0);
            @(negedge clk);
        end
        chk(n_wr == 0, "R3 no writes", n_wr, 0);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        do_load(13'h0300);
        do_byte(8'h77);
        do_stop();
        do_load(13'h0400);
        do_byte(8'h88);
        do_read();
        do_stop();
        chk(cur_addr == 13'h0301, "R5 address held", cur_addr, 13'h0301);
        wait_idle();
        chk(cur_addr == 13'h0301, "R5 address after", cur_addr, 13'h0301);
        do_stop();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && n_wr == 1, "R5 nothing extra", n_wr, 1);
        chk(wval[13'h0300] == 8'h77, "R5 data kept", wval[13'h0300], 8'h77);
    endtask

    task automatic t_protect();
        clear_log();
        wp_level = 1'b1;
        do_load(13'h17FE);
        do_byte(8'h01); do_byte(8'h02);
        do_stop(); wait_idle();
        chk(n_wr == 2 && wval[13'h17FF] == 8'h02, "R6 below region", n_wr, 2);
        clear_log();
        do_load(13'h1800);
        do_byte(8'h03); do_byte(8'h04);
        do_stop(); wait_idle();
        chk(n_wr == 0, "R6 blocked", n_wr, 0);
        clear_log();
        wp_level = 1'b0;
        do_load(13'h1FFF);
        do_byte(8'h05);
        do_stop(); wait_idle();
        chk(n_wr == 1 && wval[13'h1FFF] == 8'h05, "R6 open", wval[13'h1FFF], 8'h05);
        clear_log();
        do_load(13'h1FF0);
        wp_level = 1'b1; do_byte(8'h06);
        wp_level = 1'b0; do_byte(8'h07);
        do_stop(); wait_idle();
        chk(n_wr == 1 && !wflg[13'h1FF0] && wval[13'h1FF1] == 8'h07,
            "R11 per byte", n_wr, 1);
    endtask

    task automatic t_read();
        do_load(13'h1FFE);
        do_read();
        chk(cur_addr == 13'h1FFF, "R8 step", cur_addr, 13'h1FFF);
        do_read();
        chk(cur_addr == 13'h0000, "R8 array wrap", cur_addr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_wrap();
        t_no_data();
        t_busy_ignore();
        t_protect();
        t_read();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule